// File: doc/BRIEF.md
# Dual-Clock FIFO Controller with Threshold Flags

This block wraps a simple dual-port memory array. A static mode input selects between two uses. In queue mode, the block generates the write and read addresses itself and exposes a first-in, first-out queue. The write side runs on its own clock and the read side on another, and the two clocks need not be related. In direct mode, the caller's addresses go straight to the array, and the queue pointers and flags stay frozen.

Each side keeps a binary pointer one bit wider than the array address, together with a Gray-coded copy. The Gray copy passes into the opposite clock domain through two flip-flop stages. Each side then subtracts the converted remote pointer from its own pointer to get a local occupancy count.

The write side derives the full flag from that count, plus an almost-full flag set by a programmable level. The read side derives the empty flag, plus an almost-empty flag set by a programmable level. A write request is ignored while the queue is full, and a read request is ignored while it is empty. Read data appears one read-clock cycle after an accepted read. The mode input is expected to change only while both sides are idle.

Top module: `afifo_ctl_top`

## Requirements
- R1: While reset is asserted and right after it, both pointers are zero, `empty` and `almost_empty` are 1, and `full` and `almost_full` are 0.
- R2: In queue mode (`ram_mode`=0), words leave in the order they were accepted. Each word is on `rdata` from the first `rclk` rising edge after an accepted read (`ren`=1 with `empty`=0) until the next accepted read.
- R3: A write presented while `full`=1 is dropped: the write pointer does not advance, and the stored words are unchanged.
- R4: A read presented while `empty`=1 is dropped: the read pointer does not advance, and `rdata` keeps its value.
- R5: `full` is 1 exactly when the write-side occupancy equals the depth (2**AW). The write-side occupancy is the write pointer minus the synchronised read pointer, modulo 2**(AW+1).
- R6: `almost_full` is 1 exactly when the write-side occupancy is greater than or equal to `afull_lvl`.
- R7: `empty` is 1 exactly when the read-side occupancy is zero. The read-side occupancy is the synchronised write pointer minus the read pointer.
- R8: `almost_empty` is 1 exactly when the read-side occupancy is less than or equal to `aempty_lvl`.
- R9: Each stored pointer changes its Gray code in at most one bit per clock. A pointer change is visible in the opposite domain's flags no later than four of that domain's clock cycles later.
- R10: In direct mode (`ram_mode`=1), `wen` writes `wdata` at `waddr`, and `ren` loads the word at `raddr` into `rdata` on the next `rclk` edge. Neither pointer moves, so queue operation resumes where it stopped.
- R11: Pointers wrap without limit. A continuous stream through the queue, far longer than the depth and with both sides running concurrently, arrives complete and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side reset, active low |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side reset, active low |
| ram_mode | input | 1 | 1 = direct addressing, 0 = queue |
| wen | input | 1 | Write request |
| wdata | input | DW | Write data |
| waddr | input | AW | Direct-mode write address |
| ren | input | 1 | Read request |
| raddr | input | AW | Direct-mode read address |
| rdata | output | DW | Registered read data |
| afull_lvl | input | AW+1 | Almost-full level |
| aempty_lvl | input | AW+1 | Almost-empty level |
| full | output | 1 | Queue full (write domain) |
| almost_full | output | 1 | Occupancy at or above level (write domain) |
| empty | output | 1 | Queue empty (read domain) |
| almost_empty | output | 1 | Occupancy at or below level (read domain) |

## Verification
The bench fills the queue to exactly the depth and then pushes one more word. A design that let that extra write through would overwrite the oldest word or wrap the pointer so that `full` drops. It drains past empty and pushes one more read; a faulty block would return stale data or move the read pointer, shifting every later word. It sweeps three pairs of threshold levels, including the extreme levels 1, depth, 0 and depth-1. This catches an off-by-one in either comparison. Direct-mode traffic followed by a resumed queue transfer exposes pointers that drift while the mode is off, and a long concurrent stream on unrelated clocks exposes broken wrap or Gray conversion through lost or reordered words.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  localparam int FN_W = 16;

  function automatic logic [FN_W-1:0] to_gray(logic [FN_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [FN_W-1:0] from_gray(logic [FN_W-1:0] g);
    logic [FN_W-1:0] b;
    b[FN_W-1] = g[FN_W-1];
    for (int i = FN_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [FN_W-1:0] fill_level(logic [FN_W-1:0] mine,
                                                  logic [FN_W-1:0] theirs);
    return mine - theirs;
  endfunction
endpackage

// File: rtl/afifo_sync2.sv
module afifo_sync2 #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/afifo_wside.sv
module afifo_wside
  import afifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic        wclk,
  input  logic        wrst_n,
  input  logic        q_mode,
  input  logic        wen,
  input  logic [AW:0] rgray_s,
  input  logic [AW:0] lvl,
  output logic [AW-1:0] waddr_q,
  output logic [AW:0] wgray,
  output logic [AW:0] wbin,
  output logic        push,
  output logic        full,
  output logic        afull
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH = PW'(2 ** AW);

  logic [PW-1:0] rbin_s;
  logic [PW-1:0] occ;
  logic [PW-1:0] wbin_nx;

  assign rbin_s  = PW'(from_gray(FN_W'(rgray_s)));
  assign occ     = PW'(fill_level(FN_W'(wbin), FN_W'(rbin_s)));
  assign full    = (occ == DEPTH);
  assign afull   = (occ >= lvl);
  assign push    = q_mode & wen & ~full;
  assign wbin_nx = wbin + PW'(1);
  assign waddr_q = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (push) begin
      wbin  <= wbin_nx;
      wgray <= PW'(to_gray(FN_W'(wbin_nx)));
    end
  end
endmodule

// File: rtl/afifo_rside.sv
module afifo_rside
  import afifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic        rclk,
  input  logic        rrst_n,
  input  logic        q_mode,
  input  logic        ren,
  input  logic [AW:0] wgray_s,
  input  logic [AW:0] lvl,
  output logic [AW-1:0] raddr_q,
  output logic [AW:0] rgray,
  output logic [AW:0] rbin,
  output logic        pop,
  output logic        empty,
  output logic        aempty
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wbin_s;
  logic [PW-1:0] occ;
  logic [PW-1:0] rbin_nx;

  assign wbin_s  = PW'(from_gray(FN_W'(wgray_s)));
  assign occ     = PW'(fill_level(FN_W'(wbin_s), FN_W'(rbin)));
  assign empty   = (occ == '0);
  assign aempty  = (occ <= lvl);
  assign pop     = q_mode & ren & ~empty;
  assign rbin_nx = rbin + PW'(1);
  assign raddr_q = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (pop) begin
      rbin  <= rbin_nx;
      rgray <= PW'(to_gray(FN_W'(rbin_nx)));
    end
  end
endmodule

// File: rtl/afifo_array.sv
module afifo_array #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)  rd <= '0;
    else if (re)  rd <= mem[ra];
  end
endmodule

// File: rtl/afifo_ctl_top.sv
module afifo_ctl_top #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          ram_mode,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] waddr,
  input  logic          ren,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic [AW:0]   afull_lvl,
  input  logic [AW:0]   aempty_lvl,
  output logic          full,
  output logic          almost_full,
  output logic          empty,
  output logic          almost_empty
);
  logic          q_mode;
  logic [AW:0]   wgray, wbin, rgray, rbin;
  logic [AW:0]   wgray_s, rgray_s;
  logic [AW-1:0] waddr_q, raddr_q;
  logic          w_push, r_pop;
  logic          arr_we, arr_re;
  logic [AW-1:0] arr_wa, arr_ra;

  assign q_mode = ~ram_mode;

  afifo_wside #(.AW(AW)) u_wside (
    .wclk(wclk), .wrst_n(wrst_n), .q_mode(q_mode), .wen(wen),
    .rgray_s(rgray_s), .lvl(afull_lvl), .waddr_q(waddr_q),
    .wgray(wgray), .wbin(wbin), .push(w_push),
    .full(full), .afull(almost_full)
  );

  afifo_rside #(.AW(AW)) u_rside (
    .rclk(rclk), .rrst_n(rrst_n), .q_mode(q_mode), .ren(ren),
    .wgray_s(wgray_s), .lvl(aempty_lvl), .raddr_q(raddr_q),
    .rgray(rgray), .rbin(rbin), .pop(r_pop),
    .empty(empty), .aempty(almost_empty)
  );

  afifo_sync2 #(.W(AW + 1)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s)
  );

  afifo_sync2 #(.W(AW + 1)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s)
  );

  assign arr_we = ram_mode ? wen   : w_push;
  assign arr_wa = ram_mode ? waddr : waddr_q;
  assign arr_re = ram_mode ? ren   : r_pop;
  assign arr_ra = ram_mode ? raddr : raddr_q;

  afifo_array #(.AW(AW), .DW(DW)) u_array (
    .wclk(wclk), .we(arr_we), .wa(arr_wa), .wd(wdata),
    .rclk(rclk), .rrst_n(rrst_n), .re(arr_re), .ra(arr_ra), .rd(rdata)
  );
endmodule

// File: rtl/afifo_ctl_chk.sv
module afifo_ctl_chk #(
  parameter int AW = 4
) (
  input logic        wclk,
  input logic        wrst_n,
  input logic        rclk,
  input logic        rrst_n,
  input logic        ram_mode,
  input logic        full,
  input logic        almost_full,
  input logic        empty,
  input logic        almost_empty,
  input logic        w_push,
  input logic        r_pop,
  input logic [AW:0] wgray,
  input logic [AW:0] rgray,
  input logic [AW:0] wbin,
  input logic [AW:0] rbin
);
  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!wrst_n)
    full |=> $stable(wbin));

  assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
    empty |=> $stable(rbin));

  assert_wgray_step_R9: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  assert_rgray_step_R9: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

  assert_direct_wptr_R10: assert property (@(posedge wclk) disable iff (!wrst_n)
    ram_mode |-> !w_push);

  assert_direct_rptr_R10: assert property (@(posedge rclk) disable iff (!rrst_n)
    ram_mode |-> !r_pop);

  assert_full_flags_R6: assert property (@(posedge wclk) disable iff (!wrst_n)
    full |-> almost_full);

  assert_empty_flags_R8: assert property (@(posedge rclk) disable iff (!rrst_n)
    empty |-> almost_empty);
endmodule

bind afifo_ctl_top afifo_ctl_chk #(.AW(AW)) u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
  .ram_mode(ram_mode), .full(full), .almost_full(almost_full),
  .empty(empty), .almost_empty(almost_empty),
  .w_push(w_push), .r_pop(r_pop),
  .wgray(wgray), .rgray(rgray), .wbin(wbin), .rbin(rbin)
);

// File: tb/afifo_ctl_top_bench.sv
`timescale 1ns/1ps
module afifo_ctl_top_bench;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 16;

  logic          wclk = 0, rclk = 0, rst_n = 0;
  logic          ram_mode = 0, wen = 0, ren = 0;
  logic [DW-1:0] wdata = '0;
  logic [AW-1:0] waddr = '0, raddr = '0;
  logic [AW:0]   afull_lvl = 5'd12, aempty_lvl = 5'd3;
  logic [DW-1:0] rdata;
  logic          full, almost_full, empty, almost_empty;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4   wclk = ~wclk;
  always #5.5 rclk = ~rclk;

  afifo_ctl_top #(.AW(AW), .DW(DW)) u_afifo_ctl_top (
    .wclk(wclk), .wrst_n(rst_n), .rclk(rclk), .rrst_n(rst_n),
    .ram_mode(ram_mode), .wen(wen), .wdata(wdata), .waddr(waddr),
    .ren(ren), .raddr(raddr), .rdata(rdata),
    .afull_lvl(afull_lvl), .aempty_lvl(aempty_lvl),
    .full(full), .almost_full(almost_full),
    .empty(empty), .almost_empty(almost_empty)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_one(logic [DW-1:0] v);
    @(negedge wclk); wen = 1; wdata = v;
    @(negedge wclk); wen = 0;
  endtask

  task automatic pop_one();
    @(negedge rclk); ren = 1;
    @(negedge rclk); ren = 0;
  endtask

  task automatic settle();
    repeat (5) @(negedge rclk);
    repeat (5) @(negedge wclk);
  endtask

  int afl [3] = '{12, 1, 16};
  int ael [3] = '{3, 0, 15};

  initial begin
    #200_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] last;
    repeat (3) @(negedge wclk);
    chk("R1 empty", empty, 1);
    chk("R1 almost_empty", almost_empty, 1);
    chk("R1 full", full, 0);
    chk("R1 almost_full", almost_full, 0);
    rst_n = 1;
    repeat (2) @(negedge wclk);
    chk("R1 full after reset", full, 0);
    chk("R1 empty after reset", empty, 1);

    for (int p = 0; p < 3; p++) begin
      afull_lvl = 5'(afl[p]); aempty_lvl = 5'(ael[p]);
      for (int k = 1; k <= DEPTH; k++) begin
        push_one(8'(p * 32 + k));
        chk("R5 full while filling", full, int'(k == DEPTH));
        chk("R6 almost_full while filling", almost_full, int'(k >= afl[p]));
      end
      push_one(8'hEE);
      chk("R3 full held on extra write", full, 1);
      settle();
      chk("R9 R7 empty cleared after sync", empty, 0);
      chk("R8 almost_empty at depth", almost_empty, int'(DEPTH <= ael[p]));
      for (int k = 1; k <= DEPTH; k++) begin
        pop_one();
        chk("R2 R3 read order", rdata, p * 32 + k);
        chk("R7 empty while draining", empty, int'(k == DEPTH));
        chk("R8 almost_empty while draining", almost_empty, int'(DEPTH - k <= ael[p]));
      end
      last = rdata;
      pop_one();
      chk("R4 rdata held on empty read", rdata, int'(last));
      chk("R4 empty held", empty, 1);
      settle();
      chk("R5 full cleared after drain", full, 0);
      chk("R6 almost_full after drain", almost_full, 0);
      push_one(8'h5A);
      settle();
      pop_one();
      chk("R4 pointer unmoved by empty read", rdata, 8'h5A);
      settle();
    end

    afull_lvl = 5'd12; aempty_lvl = 5'd3;
    ram_mode = 1;
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge wclk); wen = 1; waddr = 4'(a); wdata = 8'(a ^ 8'hA5);
    end
    @(negedge wclk); wen = 0;
    for (int a = DEPTH - 1; a >= 0; a--) begin
      @(negedge rclk); ren = 1; raddr = 4'(a);
      @(negedge rclk); ren = 0;
      chk("R10 direct read", rdata, a ^ 8'hA5);
    end
    settle();
    chk("R10 empty unchanged in direct mode", empty, 1);
    chk("R10 full unchanged in direct mode", full, 0);
    ram_mode = 0;
    push_one(8'h33);
    settle();
    chk("R10 queue resumes nonempty", empty, 0);
    pop_one();
    chk("R10 queue resumes data", rdata, 8'h33);
    settle();

    fork
      begin
        int n = 0;
        while (n < 200) begin
          @(negedge wclk);
          if (!full) begin wen = 1; wdata = 8'(n); n++; end
          else wen = 0;
        end
        @(negedge wclk); wen = 0;
      end
      begin
        int got = 0;
        bit pend = 0;
        int bad = 0;
        while (got < 200) begin
          @(negedge rclk);
          if (pend) begin
            if (rdata != 8'(got)) bad++;
            got++;
          end
          pend = (!empty && got < 200) || (pend && !empty && got < 200);
          ren = pend;
        end
        ren = 0;
        chk("R11 stream words out of order", bad, 0);
      end
    join
    settle();
    chk("R11 empty after stream", empty, 1);
    chk("R11 full after stream", full, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule